// File: doc/BRIEF.md
# PWM-Locked Sample Trigger Generator

This block produces the sample command for a converter that captures all of its channels at one instant. The command is tied to a chosen point of a center-aligned PWM carrier, or to a timer pulse, or to an edge on a general-purpose input. The PWM counter itself lives outside the block. The block observes the counter value and the count direction and picks out the anchor point. The default anchor is the counter valley or peak, which is the middle of the on-time, where current ripple is smallest.

Two modes issue commands. In periodic mode a command follows every N-th accepted event. In one-shot mode an arm pulse enables exactly one command, and the block then disarms. Each command can be pushed later by a programmable number of clock cycles. New settings are written into a shadow copy and are applied only when the carrier counter passes through zero, so no carrier period ever runs with a mix of old and new settings. If an event arrives while a delayed command is still waiting, the waiting command is kept, the new event is dropped, and a sticky overrun flag is set.

Top module: `pwm_sample_trigger`

## Requirements
- R1: After reset, `sample_o`, `armed_o` and `overrun_o` are 0 and the mode is off (code 0). No command is issued until a configuration has been written and applied.
- R2: A pulse on `cfg_wr_i` captures all `cfg_*` fields. The captured values take effect in the cycle after the next cycle in which `cnt_i` is 0, and that same cycle clears `overrun_o`. An event in the zero cycle itself is still handled with the old settings.
- R3: Anchor code `cfg_anchor_i`: 0 means `cnt_i == 0`, 1 means `cnt_i == prd_i`, 2 means `cnt_i == cfg_pos_i` with `cnt_dir_i = 1` (counting up), and 3 means `cnt_i == cfg_pos_i` with `cnt_dir_i = 0`.
- R4: Source code `cfg_src_i`: 0 selects the carrier anchor of R3, 1 selects each cycle with `timer_evt_i = 1`, 2 selects a 0-to-1 transition of `gpio_i`, and 3 selects no source. A level held on `gpio_i` gives only one event.
- R5: Periodic mode (code 2) issues a command for the first event after the configuration is applied, and then for every N-th event after that, where N is `cfg_decim_i`. The values 0 and 1 both mean every event.
- R6: One-shot mode (code 1): a `shot_i` pulse sets `armed_o`. The next event issues exactly one command and clears `armed_o`. Applying any configuration also clears `armed_o`.
- R7: If an event occurs in cycle T, `sample_o` is high in cycle T + `cfg_delay_i` + 2.
- R8: `sample_o` is never high for two cycles in a row.
- R9: If an accepted event occurs while a delayed command is pending, the pending command is still issued at its scheduled cycle, the new event produces no command, and `overrun_o` goes to 1 and stays there until the next configuration apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Carrier counter value |
| cnt_dir_i | input | 1 | Carrier count direction, 1 = up |
| prd_i | input | CNT_W | Carrier peak value |
| timer_evt_i | input | 1 | Timer event pulse |
| gpio_i | input | 1 | General-purpose trigger input, synchronous |
| shot_i | input | 1 | One-shot arm pulse |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | 0 off, 1 one-shot, 2 periodic |
| cfg_src_i | input | 2 | Event source code (R4) |
| cfg_anchor_i | input | 2 | Carrier anchor code (R3) |
| cfg_pos_i | input | CNT_W | Compare position for anchor codes 2 and 3 |
| cfg_decim_i | input | DEC_W | Decimation factor N |
| cfg_delay_i | input | DLY_W | Command delay in cycles |
| sample_o | output | 1 | Single-cycle sample command |
| armed_o | output | 1 | One-shot armed status |
| overrun_o | output | 1 | Sticky delay-overrun status |

## Verification
The assertions assume that the carrier counter is 0 for exactly one cycle per period, so that each configuration apply is a single-cycle event. They also assume that `gpio_i` is already synchronous to `clk_i`. The bench counter model is a triangle counter that rises from 0 to the peak and falls back again, so each extremum is visited once per period. All stimulus inputs change only at falling clock edges. Configuration writes are always issued away from the zero cycle, or in a way that gives the same result either way. Only one delay setting is long enough to overlap the next anchor, so every overrun in the run is deliberate.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_ONESHOT  = 2'd1,
    MODE_PERIODIC = 2'd2,
    MODE_RSVD     = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SRC_CARRIER = 2'd0,
    SRC_TIMER   = 2'd1,
    SRC_GPIO    = 2'd2,
    SRC_NONE    = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ANC_VALLEY = 2'd0,
    ANC_PEAK   = 2'd1,
    ANC_UP     = 2'd2,
    ANC_DOWN   = 2'd3
  } anchor_e;
endpackage

// File: rtl/pst_cfg_shadow.sv
module pst_cfg_shadow import pst_pkg::*; #(
  parameter int CNT_W = 12,
  parameter int DEC_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_i,
  input  mode_e            mode_i,
  input  src_e             src_i,
  input  anchor_e          anc_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [DEC_W-1:0] dec_i,
  input  logic [DLY_W-1:0] dly_i,
  output mode_e            mode_o,
  output src_e             src_o,
  output anchor_e          anc_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [DEC_W-1:0] dec_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             apply_o
);
  mode_e            sh_mode;
  src_e             sh_src;
  anchor_e          sh_anc;
  logic [CNT_W-1:0] sh_pos;
  logic [DEC_W-1:0] sh_dec;
  logic [DLY_W-1:0] sh_dly;
  logic             pend_q;
  logic             boundary;

  assign boundary = (cnt_i == '0);
  assign apply_o  = boundary && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_mode <= MODE_OFF;
      sh_src  <= SRC_CARRIER;
      sh_anc  <= ANC_VALLEY;
      sh_pos  <= '0;
      sh_dec  <= '0;
      sh_dly  <= '0;
      pend_q  <= 1'b0;
    end else if (wr_i) begin
      sh_mode <= mode_i;
      sh_src  <= src_i;
      sh_anc  <= anc_i;
      sh_pos  <= pos_i;
      sh_dec  <= dec_i;
      sh_dly  <= dly_i;
      pend_q  <= 1'b1;
    end else if (apply_o) begin
      pend_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_OFF;
      src_o  <= SRC_CARRIER;
      anc_o  <= ANC_VALLEY;
      pos_o  <= '0;
      dec_o  <= '0;
      dly_o  <= '0;
    end else if (apply_o) begin
      mode_o <= sh_mode;
      src_o  <= sh_src;
      anc_o  <= sh_anc;
      pos_o  <= sh_pos;
      dec_o  <= sh_dec;
      dly_o  <= sh_dly;
    end
  end

  // R2
  cfg_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |=> $stable({mode_o, src_o, anc_o, pos_o, dec_o, dly_o}));
endmodule

// File: rtl/pst_anchor_det.sv
module pst_anchor_det import pst_pkg::*; #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] pos_i,
  input  anchor_e          anc_i,
  input  src_e             src_i,
  input  logic             timer_i,
  input  logic             gpio_i,
  output logic             hit_o
);
  logic gpio_q;
  logic carrier_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gpio_q <= 1'b0;
    else         gpio_q <= gpio_i;
  end

  always_comb begin
    unique case (anc_i)
      ANC_VALLEY: carrier_hit = (cnt_i == '0);
      ANC_PEAK:   carrier_hit = (cnt_i == prd_i);
      ANC_UP:     carrier_hit = (cnt_i == pos_i) && dir_i;
      ANC_DOWN:   carrier_hit = (cnt_i == pos_i) && !dir_i;
      default:    carrier_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (src_i)
      SRC_CARRIER: hit_o = carrier_hit;
      SRC_TIMER:   hit_o = timer_i;
      SRC_GPIO:    hit_o = gpio_i && !gpio_q;
      default:     hit_o = 1'b0;
    endcase
  end

  // R4
  gpio_level_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_GPIO && $stable(src_i) && hit_o) |=> !hit_o);
endmodule

// File: rtl/pst_fire_ctrl.sv
module pst_fire_ctrl import pst_pkg::*; #(
  parameter int DEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  mode_e            mode_i,
  input  logic [DEC_W-1:0] dec_i,
  input  logic             shot_i,
  input  logic             apply_i,
  output logic             fire_o,
  output logic             armed_o
);
  logic [DEC_W-1:0] dec_cnt_q;
  logic [DEC_W-1:0] dec_last;
  logic             per_fire;
  logic             os_fire;

  assign dec_last = (dec_i <= DEC_W'(1)) ? '0 : dec_i - DEC_W'(1);
  assign per_fire = hit_i && (mode_i == MODE_PERIODIC) && (dec_cnt_q == '0);
  assign os_fire  = hit_i && (mode_i == MODE_ONESHOT) && armed_o;
  assign fire_o   = per_fire || os_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_cnt_q <= '0;
    end else if (apply_i) begin
      dec_cnt_q <= '0;
    end else if (hit_i && mode_i == MODE_PERIODIC) begin
      dec_cnt_q <= (dec_cnt_q >= dec_last) ? '0 : dec_cnt_q + DEC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    armed_o <= 1'b0;
    else if (apply_i)                               armed_o <= 1'b0;
    else if (os_fire)                               armed_o <= 1'b0;
    else if (shot_i && mode_i == MODE_ONESHOT)      armed_o <= 1'b1;
  end

  // R6
  oneshot_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && mode_i == MODE_ONESHOT) |=> !armed_o);

  // R1
  off_no_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |-> !fire_o);
endmodule

// File: rtl/pst_delay_line.sv
module pst_delay_line #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             clr_i,
  output logic             sample_o,
  output logic             overrun_o
);
  logic             busy_q;
  logic [DLY_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rem_q    <= '0;
      sample_o <= 1'b0;
    end else begin
      sample_o <= 1'b0;
      if (busy_q) begin
        if (rem_q == '0) begin
          sample_o <= 1'b1;
          busy_q   <= 1'b0;
        end else begin
          rem_q <= rem_q - DLY_W'(1);
        end
      end else if (fire_i) begin
        busy_q <= 1'b1;
        rem_q  <= dly_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               overrun_o <= 1'b0;
    else if (clr_i)            overrun_o <= 1'b0;
    else if (fire_i && busy_q) overrun_o <= 1'b1;
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  // R9
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && busy_q && !clr_i) |=> overrun_o);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clr_i) |=> overrun_o);

  // R9
  pending_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rem_q != '0) |=> busy_q);
endmodule

// File: rtl/pwm_sample_trigger.sv
module pwm_sample_trigger import pst_pkg::*; #(
  parameter int CNT_W = 12,
  parameter int DEC_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_dir_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic             timer_evt_i,
  input  logic             gpio_i,
  input  logic             shot_i,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [1:0]       cfg_src_i,
  input  logic [1:0]       cfg_anchor_i,
  input  logic [CNT_W-1:0] cfg_pos_i,
  input  logic [DEC_W-1:0] cfg_decim_i,
  input  logic [DLY_W-1:0] cfg_delay_i,
  output logic             sample_o,
  output logic             armed_o,
  output logic             overrun_o
);
  mode_e            act_mode;
  src_e             act_src;
  anchor_e          act_anc;
  logic [CNT_W-1:0] act_pos;
  logic [DEC_W-1:0] act_dec;
  logic [DLY_W-1:0] act_dly;
  logic             apply;
  logic             hit;
  logic             fire;

  pst_cfg_shadow #(.CNT_W(CNT_W), .DEC_W(DEC_W), .DLY_W(DLY_W)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i),
    .wr_i    (cfg_wr_i),
    .mode_i  (mode_e'(cfg_mode_i)),
    .src_i   (src_e'(cfg_src_i)),
    .anc_i   (anchor_e'(cfg_anchor_i)),
    .pos_i   (cfg_pos_i),
    .dec_i   (cfg_decim_i),
    .dly_i   (cfg_delay_i),
    .mode_o  (act_mode),
    .src_o   (act_src),
    .anc_o   (act_anc),
    .pos_o   (act_pos),
    .dec_o   (act_dec),
    .dly_o   (act_dly),
    .apply_o (apply)
  );

  pst_anchor_det #(.CNT_W(CNT_W)) i_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i),
    .dir_i   (cnt_dir_i),
    .prd_i   (prd_i),
    .pos_i   (act_pos),
    .anc_i   (act_anc),
    .src_i   (act_src),
    .timer_i (timer_evt_i),
    .gpio_i  (gpio_i),
    .hit_o   (hit)
  );

  pst_fire_ctrl #(.DEC_W(DEC_W)) i_fire (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .mode_i  (act_mode),
    .dec_i   (act_dec),
    .shot_i  (shot_i),
    .apply_i (apply),
    .fire_o  (fire),
    .armed_o (armed_o)
  );

  pst_delay_line #(.DLY_W(DLY_W)) i_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .dly_i     (act_dly),
    .clr_i     (apply),
    .sample_o  (sample_o),
    .overrun_o (overrun_o)
  );
endmodule

// File: tb/test_pwm_sample_trigger.sv
module test_pwm_sample_trigger;
  localparam int CNT_W = 12;
  localparam int DEC_W = 4;
  localparam int DLY_W = 8;
  localparam int PRD   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [CNT_W-1:0] cnt;
  logic             dir;
  logic             timer_evt = 1'b0, gpio = 1'b0, shot = 1'b0, cfg_wr = 1'b0;
  logic [1:0]       cfg_mode = '0, cfg_src = '0, cfg_anc = '0;
  logic [CNT_W-1:0] cfg_pos = '0;
  logic [DEC_W-1:0] cfg_dec = '0;
  logic [DLY_W-1:0] cfg_dly = '0;
  logic             sample, armed, overrun;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int offs[$];

  always @(posedge clk) cyc <= cyc + 1;

  // triangle carrier: 0 up to PRD, back down to 0, each extremum one cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= 1'b1;
    end else begin
      cnt <= dir ? cnt + 1'b1 : cnt - 1'b1;
      if (dir && cnt == CNT_W'(PRD - 1)) dir <= 1'b0;
      else if (!dir && cnt == CNT_W'(1)) dir <= 1'b1;
    end
  end

  pwm_sample_trigger #(.CNT_W(CNT_W), .DEC_W(DEC_W), .DLY_W(DLY_W)) i_pwm_sample_trigger (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cnt_i       (cnt),
    .cnt_dir_i   (dir),
    .prd_i       (CNT_W'(PRD)),
    .timer_evt_i (timer_evt),
    .gpio_i      (gpio),
    .shot_i      (shot),
    .cfg_wr_i    (cfg_wr),
    .cfg_mode_i  (cfg_mode),
    .cfg_src_i   (cfg_src),
    .cfg_anchor_i(cfg_anc),
    .cfg_pos_i   (cfg_pos),
    .cfg_decim_i (cfg_dec),
    .cfg_delay_i (cfg_dly),
    .sample_o    (sample),
    .armed_o     (armed),
    .overrun_o   (overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int mode, input int src, input int anc,
                        input int pos, input int dec, input int dly);
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_src = 2'(src); cfg_anc = 2'(anc);
    cfg_pos = CNT_W'(pos); cfg_dec = DEC_W'(dec); cfg_dly = DLY_W'(dly);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_valley(output int v);
    do @(negedge clk); while (cnt != '0);
    v = cyc;
  endtask

  // compare recorded offsets at or above minoff with up to three expected ones
  task automatic cmp(input string req, input int n, input int e0, input int e1,
                     input int e2, input int minoff);
    int got[$];
    int exp[3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    foreach (offs[i]) if (offs[i] >= minoff) got.push_back(offs[i]);
    chk(got.size() == n, {req, " count"}, got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      chk(got[i] == exp[i], {req, " offset"}, got[i], exp[i]);
  endtask

  task automatic collect(input int v0, input int n);
    offs.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample) offs.push_back(cyc - v0);
    end
  endtask

  task automatic t_reset;
    chk(sample == 1'b0, "R1 sample", int'(sample), 0);
    chk(armed == 1'b0, "R1 armed", int'(armed), 0);
    chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
    collect(cyc, 100);
    cmp("R1 idle", 0, 0, 0, 0, 1);
  endtask

  task automatic t_deferred;
    int v0;
    do @(negedge clk); while (!(cnt == CNT_W'(10) && dir));
    wr_cfg(2, 0, 0, 0, 1, 0);
    wait_valley(v0);
    collect(v0, 125);
    // R2: the valley in the apply cycle must not fire; R5, R7 delay 0
    cmp("R2 R5 valley periodic", 3, 42, 82, 122, 1);
  endtask

  task automatic t_peak_decim;
    int v0;
    wr_cfg(2, 0, 1, 0, 3, 5);
    wait_valley(v0);
    collect(v0, 270);
    cmp("R3 R5 R7 peak decim3", 3, 27, 147, 267, 3);
  endtask

  task automatic t_up;
    int v0;
    wr_cfg(2, 0, 2, 5, 0, 3);
    wait_valley(v0);
    collect(v0, 100);
    cmp("R3 R7 up compare", 3, 10, 50, 90, 3);
  endtask

  task automatic t_down;
    int v0;
    wr_cfg(2, 0, 3, 5, 1, 0);
    wait_valley(v0);
    collect(v0, 80);
    cmp("R3 down compare", 2, 37, 77, 0, 3);
  endtask

  task automatic t_oneshot;
    int v0;
    wr_cfg(1, 0, 0, 0, 0, 1);
    wait_valley(v0);
    offs.delete();
    for (int i = 1; i <= 130; i++) begin
      @(negedge clk);
      if (sample) offs.push_back(cyc - v0);
      if (i == 5)  chk(armed == 1'b0, "R6 not armed", int'(armed), 0);
      if (i == 10) shot = 1'b1;
      if (i == 11) shot = 1'b0;
      if (i == 12) chk(armed == 1'b1, "R6 armed", int'(armed), 1);
    end
    chk(armed == 1'b0, "R6 disarmed", int'(armed), 0);
    cmp("R6 R7 oneshot", 1, 43, 0, 0, 3);
  endtask

  task automatic t_timer;
    int v0;
    wr_cfg(2, 1, 0, 0, 0, 0);
    wait_valley(v0);
    offs.delete();
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (sample) offs.push_back(cyc - v0);
      timer_evt = (i == 10 || i == 25);
    end
    cmp("R4 timer source", 2, 12, 27, 0, 3);
  endtask

  task automatic t_gpio;
    int v0;
    wr_cfg(2, 2, 0, 0, 0, 0);
    wait_valley(v0);
    offs.delete();
    for (int i = 1; i <= 45; i++) begin
      @(negedge clk);
      if (sample) offs.push_back(cyc - v0);
      if (i == 10) gpio = 1'b1;
      if (i == 20) gpio = 1'b0;
      timer_evt = (i == 30);
    end
    cmp("R4 gpio edge", 1, 12, 0, 0, 3);
  endtask

  task automatic t_overrun;
    int v0;
    int v1;
    wr_cfg(2, 0, 0, 0, 0, 50);
    wait_valley(v0);
    offs.delete();
    for (int i = 1; i <= 180; i++) begin
      @(negedge clk);
      if (sample) offs.push_back(cyc - v0);
      if (i == 70) chk(overrun == 1'b0, "R9 no overrun yet", int'(overrun), 0);
      if (i == 85) chk(overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
    end
    cmp("R9 pending kept", 2, 92, 172, 0, 3);
    chk(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);
    wr_cfg(0, 0, 0, 0, 0, 0);
    wait_valley(v1);
    @(negedge clk);
    chk(overrun == 1'b0, "R2 overrun cleared", int'(overrun), 0);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deferred();
    t_peak_decim();
    t_up();
    t_down();
    t_oneshot();
    t_timer();
    t_gpio();
    t_overrun();
    finish_sim();
  end
endmodule